// File: doc/BRIEF.md
# Two-Edge PPS Timestamp Capture

This block stamps the arrival of an asynchronous one-pulse-per-second edge with the value of a free-running counter. The counter is clocked by the rising edge of the reference clock. The pulse is brought into the reference domain twice, once through a synchronizer clocked on the rising reference edge and once through a synchronizer clocked on the falling edge. Each synchronizer latches its own copy of the count when it detects the pulse edge.

A fine-phase input states in which half of the reference period the pulse arrived. The block uses it to keep the copy whose sampling edge lay farther from the pulse transition. Both copies are first shifted by a fixed amount so that they refer to the same counter epoch. The selected stamp and both aligned copies appear together with a one-cycle valid strobe. A lockout window then suppresses further pulses so that ringing or a held-high input cannot produce a second stamp.

Top module: `pps_stamp_latch`

## Requirements
- R1: The reference counter is CNT_W bits wide (8 by default), starts at 0 after reset, advances by one on every rising reference edge, and wraps from all ones to zero.
- R2: `rise_stamp_o` equals N, the number of rising reference edges (mod 2^CNT_W) that occurred after reset and before the PPS rising transition.
- R3: `fall_stamp_o` equals N when the transition falls in the first half of the reference period (between a rising edge and the next falling edge). It equals N+1 (mod 2^CNT_W) when the transition falls in the second half.
- R4: `late_half` is held stable from the PPS transition until valid. At valid, `stamp_o` takes the rising-path stamp when `late_half` is 1 and the falling-path stamp when `late_half` is 0.
- R5: `valid_o` is high for exactly one reference cycle per accepted PPS edge. All three stamp outputs change only in that cycle and hold their values until the next valid.
- R6: With the default two-stage synchronizers, `valid_o` is first seen high after the 4th rising reference edge following a first-half transition, and after the 5th following a second-half transition.
- R7: After a valid, PPS edges within the next LOCKOUT reference cycles (1000 by default) produce no valid, and all stamp outputs stay unchanged.
- R8: Capture is edge-triggered. A PPS input that stays high for longer than the lockout yields only one valid.
- R9: While reset is asserted and right after its release, `valid_o` is low and all stamp outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; the counter runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_async | input | 1 | Asynchronous pulse-per-second input; its rising edge is stamped |
| late_half | input | 1 | 1 when the pulse arrived in the second half of the reference period |
| stamp_o | output | CNT_W | Selected, epoch-aligned timestamp |
| rise_stamp_o | output | CNT_W | Aligned capture of the rising-edge path |
| fall_stamp_o | output | CNT_W | Aligned capture of the falling-edge path |
| valid_o | output | 1 | One-cycle strobe marking new stamp values |

## Verification
On every cycle, the embedded properties check the following: counter wrap, the single-cycle width of the strobe, that the stamps do not move outside a strobe, that a path capture stays frozen once taken, and that two strobes are never closer than the lockout. Only the bench scenarios can show that the numbers themselves are right. This covers the epoch alignment of each path, the one-count disagreement of the falling path for second-half arrivals, the selection driven by the phase input (including deliberately contradictory phase values), and the exact strobe latency for each half. The bench also shows that a pulse inside the lockout, or a level held high, leaves the outputs untouched.

// File: rtl/pps_stamp_pkg.sv
`timescale 1ns/1ps
package pps_stamp_pkg;

    // Which synchronizer path supplies the final stamp
    typedef enum logic {
        PATH_RISE = 1'b0,
        PATH_FALL = 1'b1
    } path_sel_e;

    // Number of capture paths (one per reference edge polarity)
    localparam int NUM_PATHS = 2;

endpackage

// File: rtl/pps_ref_count.sv
`timescale 1ns/1ps
module pps_ref_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0));

endmodule

// File: rtl/pps_edge_capture.sv
`timescale 1ns/1ps
module pps_edge_capture #(
    parameter int CNT_W   = 8,
    parameter int DEPTH   = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_i,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] stamp_o,
    output logic             seen_o
);

    // The count has advanced DEPTH times by the capturing edge
    localparam int ADJ = DEPTH;

    typedef struct packed {
        logic [DEPTH-1:0] sync;
        logic             hist;
        logic             seen;
        logic [CNT_W-1:0] stamp;
    } cap_t;

    cap_t cap_d, cap_q;
    logic evt;

    always_comb begin
        evt          = cap_q.sync[DEPTH-1] & ~cap_q.hist;
        cap_d        = cap_q;
        cap_d.sync   = {cap_q.sync[DEPTH-2:0], pps_i};
        cap_d.hist   = cap_q.sync[DEPTH-1];
        if (!arm_i) begin
            cap_d.seen = 1'b0;
        end else if (evt && !cap_q.seen) begin
            cap_d.seen  = 1'b1;
            cap_d.stamp = cnt_i - CNT_W'(ADJ);
        end
    end

    generate
        if (FALLING) begin : g_neg
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= cap_d;
            end
        end else begin : g_pos
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= cap_d;
            end
        end
    endgenerate

    assign stamp_o = cap_q.stamp;
    assign seen_o  = cap_q.seen;

    // R2 R3: a taken capture is never overwritten while still armed
    cap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.seen && arm_i) |=> $stable(cap_q.stamp));

endmodule

// File: rtl/pps_stamp_select.sv
`timescale 1ns/1ps
module pps_stamp_select
    import pps_stamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             late_i,
    input  logic [CNT_W-1:0] rise_i,
    input  logic [CNT_W-1:0] fall_i,
    output logic [CNT_W-1:0] sel_o
);

    path_sel_e path;

    always_comb begin
        // Late arrival: the falling edge was close, trust the rising path
        path  = late_i ? PATH_RISE : PATH_FALL;
        sel_o = (path == PATH_RISE) ? rise_i : fall_i;
    end

endmodule

// File: rtl/pps_stamp_latch.sv
`timescale 1ns/1ps
module pps_stamp_latch
    import pps_stamp_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DEPTH   = 2,
    parameter int LOCKOUT = 1000
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             pps_async,
    input  logic             late_half,
    output logic [CNT_W-1:0] stamp_o,
    output logic [CNT_W-1:0] rise_stamp_o,
    output logic [CNT_W-1:0] fall_stamp_o,
    output logic             valid_o
);

    localparam int LOCK_W = $clog2(LOCKOUT + 1);

    typedef struct packed {
        logic [DEPTH-1:0]  ph;
        logic              fall_seen;
        logic              armed;
        logic [LOCK_W-1:0] lock;
        logic              valid;
        logic [CNT_W-1:0]  stamp;
        logic [CNT_W-1:0]  rise;
        logic [CNT_W-1:0]  fall;
    } top_t;

    top_t st_d, st_q;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_stamp [NUM_PATHS];
    logic             cap_seen  [NUM_PATHS];
    logic [CNT_W-1:0] sel_stamp;

    pps_ref_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    // Path 0 samples on the rising edge, path 1 on the falling edge
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        pps_edge_capture #(
            .CNT_W   (CNT_W),
            .DEPTH   (DEPTH),
            .FALLING (p == 1)
        ) u_cap (
            .clk     (clk_ref),
            .rst_n   (rst_n),
            .pps_i   (pps_async),
            .arm_i   (st_q.armed),
            .cnt_i   (cnt),
            .stamp_o (cap_stamp[p]),
            .seen_o  (cap_seen[p])
        );
    end

    pps_stamp_select #(.CNT_W(CNT_W)) u_sel (
        .late_i (st_q.ph[DEPTH-1]),
        .rise_i (cap_stamp[0]),
        .fall_i (cap_stamp[1]),
        .sel_o  (sel_stamp)
    );

    always_comb begin
        st_d           = st_q;
        st_d.ph        = {st_q.ph[DEPTH-2:0], late_half};
        st_d.fall_seen = cap_seen[1];
        st_d.valid     = 1'b0;
        if (!st_q.armed) begin
            if (st_q.lock != '0) st_d.lock  = st_q.lock - LOCK_W'(1);
            else                 st_d.armed = 1'b1;
        end else if (cap_seen[0] && st_q.fall_seen) begin
            st_d.valid = 1'b1;
            st_d.armed = 1'b0;
            st_d.lock  = LOCK_W'(LOCKOUT - 1);
            st_d.stamp = sel_stamp;
            st_d.rise  = cap_stamp[0];
            st_d.fall  = cap_stamp[1];
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamp_o      = st_q.stamp;
    assign rise_stamp_o = st_q.rise;
    assign fall_stamp_o = st_q.fall;
    assign valid_o      = st_q.valid;

    // Checker state: cycles since the previous strobe, saturating
    logic [LOCK_W-1:0] gap_q;
    logic              had_valid_q;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            gap_q       <= '0;
            had_valid_q <= 1'b0;
        end else if (valid_o) begin
            gap_q       <= LOCK_W'(1);
            had_valid_q <= 1'b1;
        end else if (gap_q < LOCK_W'(LOCKOUT)) begin
            gap_q <= gap_q + LOCK_W'(1);
        end
    end

    // R5
    valid_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    stamp_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !valid_o |-> ($stable(stamp_o) && $stable(rise_stamp_o) && $stable(fall_stamp_o)));

    // R7
    lockout_gap_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (valid_o && had_valid_q) |-> (gap_q == LOCK_W'(LOCKOUT)));

endmodule

// File: tb/pps_stamp_latch_test.sv
`timescale 1ns/1ps
module pps_stamp_latch_test;

    localparam int CNT_W   = 8;
    localparam int LOCKOUT = 1000;
    localparam int NV      = 8;
    // bit1: pulse placed in second half of the period; bit0: late_half value
    localparam logic [1:0] MODE [NV] = '{2'b00, 2'b11, 2'b01, 2'b10,
                                         2'b11, 2'b00, 2'b10, 2'b01};
    localparam int GAP [NV] = '{30, 57, 211, 5, 90, 13, 160, 44};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pps = 1'b0;
    logic             late = 1'b0;
    logic [CNT_W-1:0] stamp, rstamp, fstamp;
    logic             valid;

    int checks = 0;
    int fails  = 0;
    int bcnt   = 0;

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) bcnt <= bcnt + 1;

    pps_stamp_latch uut (
        .clk_ref      (clk),
        .rst_n        (rst_n),
        .pps_async    (pps),
        .late_half    (late),
        .stamp_o      (stamp),
        .rise_stamp_o (rstamp),
        .fall_stamp_o (fstamp),
        .valid_o      (valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Raise PPS in the chosen half and wait for the strobe; PPS stays high
    task automatic fire(input bit second, input bit ph, output int n, output int lat);
        @(posedge clk);
        #(second ? 7 : 2);
        n    = bcnt % 256;
        late = ph;
        pps  = 1'b1;
        lat  = 0;
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk); #3;
            if (valid) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic run_one(input string tag, input bit second, input bit ph);
        int n, lat, ef, es;
        fire(second, ph, n, lat);
        ef = (n + (second ? 1 : 0)) % 256;
        es = ph ? n : ef;
        chk({tag, " R6 latency"}, lat, second ? 5 : 4);
        chk({tag, " R2 rise stamp"}, rstamp, n);
        chk({tag, " R3 fall stamp"}, fstamp, ef);
        chk({tag, " R4 selected stamp"}, stamp, es);
        @(posedge clk); #3;
        chk({tag, " R5 strobe width"}, valid, 0);
        wait_cycles(6);
        pps = 1'b0;
    endtask

    initial begin
        #1_900_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int nv;
        logic [CNT_W-1:0] s0, r0, f0;
        // R9 reset state
        wait_cycles(3);
        #3;
        chk("R9 valid in reset", valid, 0);
        chk("R9 stamp in reset", stamp, 0);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(2); #3;
        chk("R9 valid after release", valid, 0);
        chk("R9 rise stamp after release", rstamp, 0);
        chk("R9 fall stamp after release", fstamp, 0);

        // Table of vectors
        for (int v = 0; v < NV; v++) begin
            wait_cycles(LOCKOUT + GAP[v]);
            run_one($sformatf("vec%0d", v), MODE[v][1], MODE[v][0]);
        end

        // R1 wrap: second-half arrival at count 255, falling path reads 0
        wait_cycles(LOCKOUT + 10);
        while ((bcnt % 256) != 254) @(posedge clk);
        run_one("wrap R1", 1'b1, 1'b0);

        // R7 lockout: pulse 100 cycles after a strobe is ignored
        wait_cycles(LOCKOUT + 20);
        run_one("pre-lockout", 1'b0, 1'b1);
        s0 = stamp; r0 = rstamp; f0 = fstamp;
        wait_cycles(90);
        pps = 1'b1;
        nv = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #3;
            if (valid) nv++;
            if (k == 10) pps = 1'b0;
        end
        chk("R7 no strobe in lockout", nv, 0);
        chk("R7 stamp unchanged", stamp, s0);
        chk("R7 rise stamp unchanged", rstamp, r0);
        chk("R7 fall stamp unchanged", fstamp, f0);

        // R7 after lockout a pulse is accepted again
        wait_cycles(LOCKOUT);
        run_one("post-lockout R7", 1'b1, 1'b1);

        // R8 held-high input gives one strobe only
        wait_cycles(LOCKOUT + 15);
        begin
            int n, lat;
            fire(1'b0, 1'b0, n, lat);
            chk("R8 first strobe", lat, 4);
            nv = 0;
            for (int k = 0; k < LOCKOUT + 100; k++) begin
                @(posedge clk); #3;
                if (valid) nv++;
            end
            chk("R8 no repeat while held", nv, 0);
            chk("R8 stamp kept", stamp, n);
            pps = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule